// File: doc/BRIEF.md
# Low-Power Mode Policy Controller

This block holds the operating mode of a two-domain chip and turns it into the clock, oscillator, regulator and power-domain controls for that mode. Domain 0 is the always-on, low-power domain. Domain 1 is the high-speed domain. Software picks a target mode class and a policy for each class. The request is committed when the processor signals wait-for-interrupt. Interrupts grouped by domain, IO wake pins, an external reset request and debug activity bring the chip back to the RUN policy that was active before it went down.

Every output is registered. An output shows the mode one cycle after `mode_class` changes. When the rate select of a clock changes, that clock's enable is held low for the cycle in which the select moves, so no clock is ever enabled while its source is switching. The STOP0 policy does not fix its peripheral-clock rate on its own: the rate follows the RUN policy that was left on entry.

Top module: `lpm_policy_ctrl`

## Requirements
- R1: After reset the controller is in RUN policy 0 and holds these outputs: mode_class 0, mode_policy 0, all five clock enables 1, all three rates 0, sysosc_en 1, fast_src_ok 1, reg_drive 3, both domain power enables 1, pd1_retain 0 and retention_lost 0.
- R2: Mode class codes are RUN=0, SLEEP=1, STOP=2, STANDBY=3, SHUTDOWN=4. A request is taken only in RUN, and only in a cycle where wfi is 1. A request made while wfi is 0 is ignored, and so is a class code from 5 to 7. A RUN request with wfi changes the active RUN policy. The policy is taken from run_pol, sleep_pol or stop_pol, or from stby_pol for STANDBY.
- R3: Rate codes are 0 = fast (80 MHz for the CPU and main clocks, 40 MHz for the low-power peripheral clock), 1 = 4 MHz and 2 = 32 kHz. RUN0 and SLEEP0 use rate 0 on all three clocks. Policies 1 and 2 use rate 2. A policy value of 3 on any 2-bit policy input is treated as 2.
- R4: In RUN and SLEEP, sysosc_en is 1 for policies 0 and 1 and 0 for policy 2. fast_src_ok, the permission for the PLL and the fast crystal, is 1 only in RUN0 and SLEEP0.
- R5: STOP1 drives the peripheral clock at rate 1 with sysosc_en 1. STOP2 drives it at rate 2 with sysosc_en 0. In STOP0 the result depends on the RUN policy left on entry: after RUN0 it is rate 1 with sysosc_en 1, after RUN1 it is rate 2 with sysosc_en 1, and after RUN2 it is rate 2 with sysosc_en 0.
- R6: cpuclk_en is 1 only in RUN. mclk_en is 0 in STOP, STANDBY and SHUTDOWN. ulpclk_en is 0 only in STANDBY1 and SHUTDOWN. lptmr_clk_en, the clock for the two low-power timers and the real-time clock, and lfclk_en are 0 only in SHUTDOWN.
- R7: reg_drive is 3 (full) in RUN and SLEEP, 2 (reduced) in STOP, 1 (low) in STANDBY and 0 (off) in SHUTDOWN.
- R8: pd0_pwr_en is 0 only in SHUTDOWN. pd1_pwr_en is 1 in RUN, SLEEP and STOP and 0 in STANDBY and SHUTDOWN. pd1_retain is 1 only in STANDBY.
- R9: SLEEP wakes on any bit of irq_pd0 or irq_pd1. STOP and STANDBY wake only on irq_pd0. SHUTDOWN wakes only on wake_io, ext_rst_wake or dbg_wake. Every other event leaves the mode unchanged.
- R10: Leaving SLEEP, STOP or STANDBY returns the controller to the RUN policy that was active at entry. Changes to run_pol while in a low-power mode have no effect on that return.
- R11: Leaving SHUTDOWN goes to RUN0 and sets retention_lost to 1. The flag stays 1 until the next accepted request.
- R12: Any change of cpu_rate, mclk_rate or ulp_rate takes place in a cycle where the matching enable is 0. The enable takes its mode value again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi | input | 1 | Processor wait-for-interrupt; commits a pending request |
| req_class | input | 3 | Requested mode class |
| run_pol | input | 2 | Policy for RUN requests |
| sleep_pol | input | 2 | Policy for SLEEP requests |
| stop_pol | input | 2 | Policy for STOP requests |
| stby_pol | input | 1 | Policy for STANDBY requests |
| irq_pd0 | input | IRQ0_W | Interrupt lines of domain 0 |
| irq_pd1 | input | IRQ1_W | Interrupt lines of domain 1 |
| wake_io | input | WAKE_W | IO wake events |
| ext_rst_wake | input | 1 | External reset pin wake request |
| dbg_wake | input | 1 | Debug-port wake request |
| mode_class | output | 3 | Current mode class |
| mode_policy | output | 2 | Current policy |
| cpuclk_en | output | 1 | CPU clock enable |
| mclk_en | output | 1 | Main clock enable to domain 1 |
| ulpclk_en | output | 1 | Low-power peripheral clock enable to domain 0 |
| lfclk_en | output | 1 | Low-frequency clock enable |
| lptmr_clk_en | output | 1 | Clock enable for the low-power timers and real-time clock |
| cpu_rate | output | 2 | CPU clock rate select |
| mclk_rate | output | 2 | Main clock rate select |
| ulp_rate | output | 2 | Low-power peripheral clock rate select |
| sysosc_en | output | 1 | System oscillator enable |
| fast_src_ok | output | 1 | Permission for PLL and fast crystal |
| reg_drive | output | 2 | Core regulator drive level |
| pd0_pwr_en | output | 1 | Domain 0 power enable |
| pd1_pwr_en | output | 1 | Domain 1 power enable |
| pd1_retain | output | 1 | Domain 1 powered down with state held |
| retention_lost | output | 1 | Configuration lost in SHUTDOWN |

## Verification
A wake event and a clock-source handoff can land in the same cycle. The bench shows this by entering STOP0 from RUN0 and raising a domain-0 interrupt in the very next cycle. The peripheral-clock select then moves from fast to 4 MHz and straight back to fast on two consecutive edges. The bench checks that the enable stays low across both moves and returns one cycle after the second, and that the run state reached at the end equals RUN0. A monitor watches every rate change for the whole run and reports any cycle where a select moves while its enable is high.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      MC_RUN   = 3'd0,
      MC_SLEEP = 3'd1,
      MC_STOP  = 3'd2,
      MC_STBY  = 3'd3,
      MC_SHDN  = 3'd4
   } mode_cls_e;

   typedef enum logic [1:0] {
      RT_FAST = 2'd0,
      RT_MID  = 2'd1,
      RT_LF   = 2'd2
   } rate_e;

   typedef enum logic [1:0] {
      DRV_OFF  = 2'd0,
      DRV_LOW  = 2'd1,
      DRV_RED  = 2'd2,
      DRV_FULL = 2'd3
   } drive_e;

   localparam int NUM_HCLK = 3;  // cpu, main, low-power peripheral

   typedef struct packed {
      logic   cpu_en;
      logic   mclk_en;
      logic   ulp_en;
      logic   lf_en;
      logic   tmr_en;
      rate_e  cpu_rt;
      rate_e  mclk_rt;
      rate_e  ulp_rt;
      logic   osc_en;
      logic   fast_ok;
      drive_e drive;
      logic   pd0_on;
      logic   pd1_on;
      logic   pd1_ret;
   } ctl_vec_t;

   function automatic logic [1:0] pol_clamp(input logic [1:0] p);
      return (p == 2'd3) ? 2'd2 : p;
   endfunction

endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
   parameter int IRQ0_W = 8,
   parameter int IRQ1_W = 8,
   parameter int WAKE_W = 4
) (
   input  logic [IRQ0_W-1:0] irq_pd0,
   input  logic [IRQ1_W-1:0] irq_pd1,
   input  logic [WAKE_W-1:0] wake_io,
   input  logic              ext_rst_wake,
   input  logic              dbg_wake,
   output logic              wake_any_irq,
   output logic              wake_pd0_irq,
   output logic              wake_pin
);
   always_comb begin
      wake_pd0_irq = |irq_pd0;
      wake_any_irq = (|irq_pd0) | (|irq_pd1);
      wake_pin     = (|wake_io) | ext_rst_wake | dbg_wake;
   end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wfi,
   input  logic [2:0] req_class,
   input  logic [1:0] run_pol,
   input  logic [1:0] sleep_pol,
   input  logic [1:0] stop_pol,
   input  logic       stby_pol,
   input  logic       wake_any_irq,
   input  logic       wake_pd0_irq,
   input  logic       wake_pin,
   output mode_cls_e  cls_q,
   output logic [1:0] pol_q,
   output logic [1:0] run_saved_q,
   output logic       lost_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q       <= MC_RUN;
         pol_q       <= 2'd0;
         run_saved_q <= 2'd0;
         lost_q      <= 1'b0;
      end else begin
         unique case (cls_q)
            MC_RUN: begin
               if (wfi) begin
                  case (req_class)
                     3'd0: begin
                        pol_q  <= pol_clamp(run_pol);
                        lost_q <= 1'b0;
                     end
                     3'd1: begin
                        cls_q       <= MC_SLEEP;
                        pol_q       <= pol_clamp(sleep_pol);
                        run_saved_q <= pol_q;
                        lost_q      <= 1'b0;
                     end
                     3'd2: begin
                        cls_q       <= MC_STOP;
                        pol_q       <= pol_clamp(stop_pol);
                        run_saved_q <= pol_q;
                        lost_q      <= 1'b0;
                     end
                     3'd3: begin
                        cls_q       <= MC_STBY;
                        pol_q       <= {1'b0, stby_pol};
                        run_saved_q <= pol_q;
                        lost_q      <= 1'b0;
                     end
                     3'd4: begin
                        cls_q       <= MC_SHDN;
                        pol_q       <= 2'd0;
                        run_saved_q <= pol_q;
                        lost_q      <= 1'b0;
                     end
                     default: ;
                  endcase
               end
            end
            MC_SLEEP: begin
               if (wake_any_irq) begin
                  cls_q <= MC_RUN;
                  pol_q <= run_saved_q;
               end
            end
            MC_STOP, MC_STBY: begin
               if (wake_pd0_irq) begin
                  cls_q <= MC_RUN;
                  pol_q <= run_saved_q;
               end
            end
            MC_SHDN: begin
               if (wake_pin) begin
                  cls_q       <= MC_RUN;
                  pol_q       <= 2'd0;
                  run_saved_q <= 2'd0;
                  lost_q      <= 1'b1;
               end
            end
            default: begin
               cls_q <= MC_RUN;
               pol_q <= 2'd0;
            end
         endcase
      end
   end
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
   import lpm_pkg::*;
(
   input  mode_cls_e  cls,
   input  logic [1:0] pol,
   input  logic [1:0] run_saved,
   output ctl_vec_t   ctl
);
   always_comb begin
      ctl         = '0;
      ctl.lf_en   = 1'b1;
      ctl.tmr_en  = 1'b1;
      ctl.pd0_on  = 1'b1;
      ctl.pd1_on  = 1'b1;
      ctl.cpu_rt  = RT_LF;
      ctl.mclk_rt = RT_LF;
      ctl.ulp_rt  = RT_LF;
      ctl.drive   = DRV_OFF;
      unique case (cls)
         MC_RUN, MC_SLEEP: begin
            ctl.cpu_en  = (cls == MC_RUN);
            ctl.mclk_en = 1'b1;
            ctl.ulp_en  = 1'b1;
            ctl.cpu_rt  = (pol == 2'd0) ? RT_FAST : RT_LF;
            ctl.mclk_rt = (pol == 2'd0) ? RT_FAST : RT_LF;
            ctl.ulp_rt  = (pol == 2'd0) ? RT_FAST : RT_LF;
            ctl.osc_en  = (pol != 2'd2);
            ctl.fast_ok = (pol == 2'd0);
            ctl.drive   = DRV_FULL;
         end
         MC_STOP: begin
            ctl.ulp_en = 1'b1;
            ctl.drive  = DRV_RED;
            case (pol)
               2'd0: begin
                  ctl.ulp_rt = (run_saved == 2'd0) ? RT_MID : RT_LF;
                  ctl.osc_en = (run_saved != 2'd2);
               end
               2'd1: begin
                  ctl.ulp_rt = RT_MID;
                  ctl.osc_en = 1'b1;
               end
               default: begin
                  ctl.ulp_rt = RT_LF;
                  ctl.osc_en = 1'b0;
               end
            endcase
         end
         MC_STBY: begin
            ctl.ulp_en  = (pol == 2'd0);
            ctl.drive   = DRV_LOW;
            ctl.pd1_on  = 1'b0;
            ctl.pd1_ret = 1'b1;
         end
         default: begin
            ctl.lf_en  = 1'b0;
            ctl.tmr_en = 1'b0;
            ctl.pd0_on = 1'b0;
            ctl.pd1_on = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/lpm_clk_handoff.sv
module lpm_clk_handoff #(
   parameter int              RT_W         = 2,
   parameter bit              GLITCH_GUARD = 1'b1,
   parameter logic [RT_W-1:0] RST_RATE     = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tgt_en,
   input  logic [RT_W-1:0] tgt_rate,
   output logic            clk_en,
   output logic [RT_W-1:0] rate_sel
);
   logic            en_q;
   logic [RT_W-1:0] rate_q;

   generate
      if (GLITCH_GUARD) begin : g_guard
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rate_q <= RST_RATE;
               en_q   <= 1'b1;
            end else if (tgt_rate != rate_q) begin
               rate_q <= tgt_rate;
               en_q   <= 1'b0;
            end else begin
               en_q <= tgt_en;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rate_q <= RST_RATE;
               en_q   <= 1'b1;
            end else begin
               rate_q <= tgt_rate;
               en_q   <= tgt_en;
            end
         end
      end
   endgenerate

   assign clk_en   = en_q;
   assign rate_sel = rate_q;
endmodule

// File: rtl/lpm_policy_ctrl.sv
module lpm_policy_ctrl
   import lpm_pkg::*;
#(
   parameter int IRQ0_W       = 8,
   parameter int IRQ1_W       = 8,
   parameter int WAKE_W       = 4,
   parameter bit GLITCH_GUARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wfi,
   input  logic [2:0]        req_class,
   input  logic [1:0]        run_pol,
   input  logic [1:0]        sleep_pol,
   input  logic [1:0]        stop_pol,
   input  logic              stby_pol,
   input  logic [IRQ0_W-1:0] irq_pd0,
   input  logic [IRQ1_W-1:0] irq_pd1,
   input  logic [WAKE_W-1:0] wake_io,
   input  logic              ext_rst_wake,
   input  logic              dbg_wake,
   output logic [2:0]        mode_class,
   output logic [1:0]        mode_policy,
   output logic              cpuclk_en,
   output logic              mclk_en,
   output logic              ulpclk_en,
   output logic              lfclk_en,
   output logic              lptmr_clk_en,
   output logic [1:0]        cpu_rate,
   output logic [1:0]        mclk_rate,
   output logic [1:0]        ulp_rate,
   output logic              sysosc_en,
   output logic              fast_src_ok,
   output logic [1:0]        reg_drive,
   output logic              pd0_pwr_en,
   output logic              pd1_pwr_en,
   output logic              pd1_retain,
   output logic              retention_lost
);
   localparam int RT_W = $bits(rate_e);

   generate
      if (IRQ0_W < 1) begin : g_bad_irq0
         $error("IRQ0_W must be at least 1");
      end
      if (IRQ1_W < 1) begin : g_bad_irq1
         $error("IRQ1_W must be at least 1");
      end
      if (WAKE_W < 1) begin : g_bad_wake
         $error("WAKE_W must be at least 1");
      end
   endgenerate

   logic       wk_any, wk_pd0, wk_pin;
   mode_cls_e  cls_q;
   logic [1:0] pol_q, saved_q;
   logic       lost_q;
   ctl_vec_t   ctl;

   lpm_wake_sel #(
      .IRQ0_W(IRQ0_W), .IRQ1_W(IRQ1_W), .WAKE_W(WAKE_W)
   ) u_wake (
      .irq_pd0      (irq_pd0),
      .irq_pd1      (irq_pd1),
      .wake_io      (wake_io),
      .ext_rst_wake (ext_rst_wake),
      .dbg_wake     (dbg_wake),
      .wake_any_irq (wk_any),
      .wake_pd0_irq (wk_pd0),
      .wake_pin     (wk_pin)
   );

   lpm_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .wfi          (wfi),
      .req_class    (req_class),
      .run_pol      (run_pol),
      .sleep_pol    (sleep_pol),
      .stop_pol     (stop_pol),
      .stby_pol     (stby_pol),
      .wake_any_irq (wk_any),
      .wake_pd0_irq (wk_pd0),
      .wake_pin     (wk_pin),
      .cls_q        (cls_q),
      .pol_q        (pol_q),
      .run_saved_q  (saved_q),
      .lost_q       (lost_q)
   );

   lpm_out_decode u_dec (
      .cls       (cls_q),
      .pol       (pol_q),
      .run_saved (saved_q),
      .ctl       (ctl)
   );

   // switched clocks: index 0 cpu, 1 main, 2 low-power peripheral
   logic            tgt_en [NUM_HCLK];
   logic [RT_W-1:0] tgt_rt [NUM_HCLK];
   logic            hc_en  [NUM_HCLK];
   logic [RT_W-1:0] hc_rt  [NUM_HCLK];

   always_comb begin
      tgt_en[0] = ctl.cpu_en;
      tgt_en[1] = ctl.mclk_en;
      tgt_en[2] = ctl.ulp_en;
      tgt_rt[0] = ctl.cpu_rt;
      tgt_rt[1] = ctl.mclk_rt;
      tgt_rt[2] = ctl.ulp_rt;
   end

   generate
      for (genvar gi = 0; gi < NUM_HCLK; gi++) begin : g_hclk
         lpm_clk_handoff #(
            .RT_W         (RT_W),
            .GLITCH_GUARD (GLITCH_GUARD),
            .RST_RATE     (RT_W'(RT_FAST))
         ) u_ho (
            .clk      (clk),
            .rst_n    (rst_n),
            .tgt_en   (tgt_en[gi]),
            .tgt_rate (tgt_rt[gi]),
            .clk_en   (hc_en[gi]),
            .rate_sel (hc_rt[gi])
         );
      end
   endgenerate

   // plain controls, registered to match the handoff latency
   logic lf_q, tmr_q, osc_q, fok_q, pd0_q, pd1_q, ret_q;
   logic [1:0] drv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lf_q  <= 1'b1;
         tmr_q <= 1'b1;
         osc_q <= 1'b1;
         fok_q <= 1'b1;
         drv_q <= DRV_FULL;
         pd0_q <= 1'b1;
         pd1_q <= 1'b1;
         ret_q <= 1'b0;
      end else begin
         lf_q  <= ctl.lf_en;
         tmr_q <= ctl.tmr_en;
         osc_q <= ctl.osc_en;
         fok_q <= ctl.fast_ok;
         drv_q <= ctl.drive;
         pd0_q <= ctl.pd0_on;
         pd1_q <= ctl.pd1_on;
         ret_q <= ctl.pd1_ret;
      end
   end

   assign mode_class     = cls_q;
   assign mode_policy    = pol_q;
   assign retention_lost = lost_q;
   assign cpuclk_en      = hc_en[0];
   assign mclk_en        = hc_en[1];
   assign ulpclk_en      = hc_en[2];
   assign cpu_rate       = hc_rt[0];
   assign mclk_rate      = hc_rt[1];
   assign ulp_rate       = hc_rt[2];
   assign lfclk_en       = lf_q;
   assign lptmr_clk_en   = tmr_q;
   assign sysosc_en      = osc_q;
   assign fast_src_ok    = fok_q;
   assign reg_drive      = drv_q;
   assign pd0_pwr_en     = pd0_q;
   assign pd1_pwr_en     = pd1_q;
   assign pd1_retain     = ret_q;
endmodule

// File: rtl/lpm_policy_ctrl_chk.sv
module lpm_policy_ctrl_chk #(
   parameter int IRQ0_W = 8,
   parameter int WAKE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IRQ0_W-1:0] irq_pd0,
   input logic [WAKE_W-1:0] wake_io,
   input logic              ext_rst_wake,
   input logic              dbg_wake,
   input logic [2:0]        mode_class,
   input logic [1:0]        mode_policy,
   input logic              cpuclk_en,
   input logic              mclk_en,
   input logic              ulpclk_en,
   input logic              lfclk_en,
   input logic [1:0]        cpu_rate,
   input logic [1:0]        mclk_rate,
   input logic [1:0]        ulp_rate,
   input logic              fast_src_ok,
   input logic [1:0]        reg_drive,
   input logic              retention_lost
);
   a_r12_cpu_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rate != $past(cpu_rate)) |-> !cpuclk_en);
   a_r12_mclk_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (mclk_rate != $past(mclk_rate)) |-> !mclk_en);
   a_r12_ulp_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (ulp_rate != $past(ulp_rate)) |-> !ulpclk_en);
   a_r6_cpu_only_run: assert property (@(posedge clk) disable iff (!rst_n)
      cpuclk_en |-> ($past(mode_class) == 3'd0));
   a_r6_lf_off_shdn: assert property (@(posedge clk) disable iff (!rst_n)
      lfclk_en |-> ($past(mode_class) != 3'd4));
   a_r4_fast_src_pol0: assert property (@(posedge clk) disable iff (!rst_n)
      fast_src_ok |-> ($past(mode_policy) == 2'd0 && $past(mode_class) <= 3'd1));
   a_r7_drive_off_shdn: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_drive == 2'd0) |-> ($past(mode_class) == 3'd4));
   a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_class == 3'd2 && !(|irq_pd0)) |=> (mode_class == 3'd2));
   a_r9_shdn_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_class == 3'd4 && !(|wake_io) && !ext_rst_wake && !dbg_wake)
         |=> (mode_class == 3'd4));
   a_r11_lost_from_shdn: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(retention_lost) |-> ($past(mode_class) == 3'd4 && mode_class == 3'd0));
   a_r6_mclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
      mclk_en |-> ($past(mode_class) <= 3'd1));
endmodule

bind lpm_policy_ctrl lpm_policy_ctrl_chk #(
   .IRQ0_W(IRQ0_W), .WAKE_W(WAKE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .irq_pd0        (irq_pd0),
   .wake_io        (wake_io),
   .ext_rst_wake   (ext_rst_wake),
   .dbg_wake       (dbg_wake),
   .mode_class     (mode_class),
   .mode_policy    (mode_policy),
   .cpuclk_en      (cpuclk_en),
   .mclk_en        (mclk_en),
   .ulpclk_en      (ulpclk_en),
   .lfclk_en       (lfclk_en),
   .cpu_rate       (cpu_rate),
   .mclk_rate      (mclk_rate),
   .ulp_rate       (ulp_rate),
   .fast_src_ok    (fast_src_ok),
   .reg_drive      (reg_drive),
   .retention_lost (retention_lost)
);

// File: tb/lpm_policy_ctrl_bench.sv
module lpm_policy_ctrl_bench;
   localparam int IRQ0_W = 8;
   localparam int IRQ1_W = 8;
   localparam int WAKE_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi = 1'b0;
   logic [2:0] req_class = '0;
   logic [1:0] run_pol = '0, sleep_pol = '0, stop_pol = '0;
   logic stby_pol = 1'b0;
   logic [IRQ0_W-1:0] irq_pd0 = '0;
   logic [IRQ1_W-1:0] irq_pd1 = '0;
   logic [WAKE_W-1:0] wake_io = '0;
   logic ext_rst_wake = 1'b0, dbg_wake = 1'b0;

   logic [2:0] mode_class;
   logic [1:0] mode_policy, cpu_rate, mclk_rate, ulp_rate, reg_drive;
   logic cpuclk_en, mclk_en, ulpclk_en, lfclk_en, lptmr_clk_en;
   logic sysosc_en, fast_src_ok, pd0_pwr_en, pd1_pwr_en, pd1_retain, retention_lost;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lpm_policy_ctrl #(.IRQ0_W(IRQ0_W), .IRQ1_W(IRQ1_W), .WAKE_W(WAKE_W)) u_lpm_policy_ctrl (
      .clk(clk), .rst_n(rst_n), .wfi(wfi), .req_class(req_class),
      .run_pol(run_pol), .sleep_pol(sleep_pol), .stop_pol(stop_pol), .stby_pol(stby_pol),
      .irq_pd0(irq_pd0), .irq_pd1(irq_pd1), .wake_io(wake_io),
      .ext_rst_wake(ext_rst_wake), .dbg_wake(dbg_wake),
      .mode_class(mode_class), .mode_policy(mode_policy),
      .cpuclk_en(cpuclk_en), .mclk_en(mclk_en), .ulpclk_en(ulpclk_en),
      .lfclk_en(lfclk_en), .lptmr_clk_en(lptmr_clk_en),
      .cpu_rate(cpu_rate), .mclk_rate(mclk_rate), .ulp_rate(ulp_rate),
      .sysosc_en(sysosc_en), .fast_src_ok(fast_src_ok), .reg_drive(reg_drive),
      .pd0_pwr_en(pd0_pwr_en), .pd1_pwr_en(pd1_pwr_en), .pd1_retain(pd1_retain),
      .retention_lost(retention_lost)
   );

   wire [23:0] obs = {mode_class, mode_policy, cpuclk_en, mclk_en, ulpclk_en, lfclk_en,
                      lptmr_clk_en, cpu_rate, mclk_rate, ulp_rate, sysosc_en, fast_src_ok,
                      reg_drive, pd0_pwr_en, pd1_pwr_en, pd1_retain, retention_lost};

   // expected steady outputs, built from the requirement tables
   function automatic logic [23:0] expv(int c, int p, int s, bit lost);
      logic ce, me, ue, le, te, osc, fo, p0, p1, pr;
      logic [1:0] cr, mr, ur, dr;
      ce = 0; me = 0; ue = 0; le = 1; te = 1; osc = 0; fo = 0;
      p0 = 1; p1 = 1; pr = 0; cr = 2; mr = 2; ur = 2; dr = 0;
      case (c)
         0, 1: begin                       // R3 R4 R6 R7
            ce = (c == 0); me = 1; ue = 1;
            cr = (p == 0) ? 2'd0 : 2'd2; mr = cr; ur = cr;
            osc = (p != 2); fo = (p == 0); dr = 3;
         end
         2: begin                          // R5
            ue = 1; dr = 2;
            if (p == 0) begin ur = (s == 0) ? 2'd1 : 2'd2; osc = (s != 2); end
            else if (p == 1) begin ur = 1; osc = 1; end
            else begin ur = 2; osc = 0; end
         end
         3: begin ue = (p == 0); dr = 1; p1 = 0; pr = 1; end   // R8
         default: begin le = 0; te = 0; p0 = 0; p1 = 0; end
      endcase
      return {3'(c), 2'(p), ce, me, ue, le, te, cr, mr, ur, osc, fo, dr, p0, p1, pr, lost};
   endfunction

   // scoreboard
   logic [23:0] exp_q[$];
   string       tag_q[$];

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [23:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (obs !== e) begin
            errors++;
            $display("FAIL %s: actual %06h expected %06h", t, obs, e);
         end
      end
   end

   // R12 monitor: a rate select may only move while its enable is low
   logic [1:0] pr_c = 0, pr_m = 0, pr_u = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_rate != pr_c) begin
            checks++;
            if (cpuclk_en) begin errors++; $display("FAIL R12 cpu: actual en 1 expected 0"); end
         end
         if (mclk_rate != pr_m) begin
            checks++;
            if (mclk_en) begin errors++; $display("FAIL R12 main: actual en 1 expected 0"); end
         end
         if (ulp_rate != pr_u) begin
            checks++;
            if (ulpclk_en) begin errors++; $display("FAIL R12 ulp: actual en 1 expected 0"); end
         end
      end
      pr_c = cpu_rate; pr_m = mclk_rate; pr_u = ulp_rate;
   end

   task automatic expect_state(string tag, logic [23:0] e);
      repeat (4) @(negedge clk);
      @(posedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic req(int c, int p, bit w = 1'b1);
      req_class = 3'(c);
      case (c)
         0: run_pol = 2'(p);
         1: sleep_pol = 2'(p);
         2: stop_pol = 2'(p);
         3: stby_pol = 1'(p);
         default: ;
      endcase
      wfi = w;
      @(negedge clk);
      wfi = 1'b0;
   endtask

   task automatic pulse(int which);
      case (which)
         0: irq_pd0 = 8'h10;
         1: irq_pd1 = 8'h02;
         2: wake_io = 4'h4;
         3: ext_rst_wake = 1'b1;
         default: dbg_wake = 1'b1;
      endcase
      @(negedge clk);
      irq_pd0 = '0; irq_pd1 = '0; wake_io = '0; ext_rst_wake = 0; dbg_wake = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_state("R1 reset state", expv(0, 0, 0, 0));
      rst_n = 1'b1;
      expect_state("R1 after release", expv(0, 0, 0, 0));

      // R2: no wfi, bad class code
      req(1, 0, 1'b0);
      expect_state("R2 request without wfi", expv(0, 0, 0, 0));
      req(6, 0);
      expect_state("R2 class code 6 ignored", expv(0, 0, 0, 0));

      // R12 handoff on RUN0 -> RUN1
      req(0, 1);
      @(negedge clk);
      chk("R12 cpu rate moved with en low", {cpu_rate, cpuclk_en}, {2'd2, 1'b0});
      @(negedge clk);
      chk("R12 cpu en back", cpuclk_en, 1);
      expect_state("R3 RUN1", expv(0, 1, 0, 0));
      req(0, 3);
      expect_state("R3 policy 3 clamps to RUN2", expv(0, 2, 0, 0));

      // SLEEP0 from RUN2, run_pol changed while asleep, wake via domain 1
      req(1, 0);
      run_pol = 2'd0;
      expect_state("R4 R6 SLEEP0", expv(1, 0, 0, 0));
      pulse(1);
      expect_state("R9 R10 SLEEP wakes on domain 1 irq to RUN2", expv(0, 2, 0, 0));
      req(1, 2);
      expect_state("R4 SLEEP2 osc off", expv(1, 2, 0, 0));
      pulse(0);
      expect_state("R9 SLEEP wakes on domain 0 irq", expv(0, 2, 0, 0));

      // STOP0 after each RUN policy (R5)
      for (int rp = 0; rp < 3; rp++) begin
         req(0, rp);
         expect_state("R3 set RUN policy", expv(0, rp, 0, 0));
         req(2, 0);
         expect_state("R5 STOP0 follows RUN policy", expv(2, 0, rp, 0));
         pulse(1);
         pulse(2);
         expect_state("R9 STOP ignores domain 1 irq and io wake", expv(2, 0, rp, 0));
         pulse(0);
         expect_state("R10 STOP wake returns to RUN policy", expv(0, rp, 0, 0));
      end
      req(2, 1);
      expect_state("R5 R7 STOP1", expv(2, 1, 0, 0));
      pulse(0);
      req(2, 3);
      expect_state("R5 STOP2 via clamp", expv(2, 2, 0, 0));
      pulse(0);
      expect_state("R10 back to RUN2", expv(0, 2, 0, 0));

      // STANDBY
      req(0, 1);
      req(3, 0);
      expect_state("R6 R7 R8 STANDBY0", expv(3, 0, 0, 0));
      pulse(1);
      expect_state("R9 STANDBY ignores domain 1 irq", expv(3, 0, 0, 0));
      pulse(0);
      expect_state("R10 STANDBY wake to RUN1", expv(0, 1, 0, 0));
      req(3, 1);
      expect_state("R6 R8 STANDBY1 peripheral clock off", expv(3, 1, 0, 0));
      pulse(0);

      // SHUTDOWN
      req(4, 0);
      expect_state("R6 R7 R8 SHUTDOWN", expv(4, 0, 0, 0));
      pulse(0);
      pulse(1);
      expect_state("R9 SHUTDOWN ignores interrupts", expv(4, 0, 0, 0));
      pulse(2);
      expect_state("R11 io wake to RUN0 with lost flag", expv(0, 0, 0, 1));
      req(1, 1);
      expect_state("R11 flag cleared on next request", expv(1, 1, 0, 0));
      pulse(0);
      req(4, 0);
      pulse(3);
      expect_state("R11 reset-pin wake", expv(0, 0, 0, 1));
      req(4, 0);
      pulse(4);
      expect_state("R11 debug wake", expv(0, 0, 0, 1));
      req(0, 0);

      // wake in the cycle after STOP0 entry, on top of a rate handoff
      expect_state("R1 RUN0 before race", expv(0, 0, 0, 0));
      req(2, 0);
      pulse(0);
      chk("R12 ulp to 4 MHz with en low", {ulp_rate, ulpclk_en}, {2'd1, 1'b0});
      @(negedge clk);
      chk("R12 ulp back to fast with en low", {ulp_rate, ulpclk_en}, {2'd0, 1'b0});
      @(negedge clk);
      chk("R12 ulp en restored", ulpclk_en, 1);
      expect_state("R10 race ends in RUN0", expv(0, 0, 0, 0));

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule